// File: doc/BRIEF.md
# Execute-Gated RAM Bus Slave

This block is a small byte-wide RAM device that sits on a strobed memory bus. The bus master selects what the device does through a three-bit mode input. It then qualifies each action with a strobe, sampled once per clock. Data and addresses travel over one bidirectional eight-bit bus. The device keeps two independent address pointers. The data pointer serves loads, stores and data reads. The fetch pointer serves instruction reads. Each pointer is loaded from the bus in its own mode and steps by one on every strobe that uses it.

Instruction reads are gated by a hidden execute-unlock register. This register is mapped at one data address, set by a parameter, and it shadows no RAM byte there. The register can only be written on the first write strobe of a write phase, and that write phase must follow directly after the data pointer was loaded with the register's address. Writing 0xAA opens instruction reads. Writing any other byte closes them. While closed, a fetch puts 0xFF on the bus and leaves the RAM alone. A read at the register's address also returns 0xFF. Power-on reset and standby both clear the register to 0x00.

The control core is a phase machine with eight states:
- PH_IDLE: no mode, or standby.
- PH_ADDR_PEND: the load-data-pointer mode is active and no strobe has come yet.
- PH_ADDR_DONE: the data pointer has been loaded in the current load phase.
- PH_WR_FIRST: the write mode was entered straight from PH_ADDR_DONE, and its first strobe is still pending.
- PH_WR_NEXT: all other write strobes.
- PH_READ, PH_FETCH and PH_SPC: data read, instruction fetch and fetch-pointer load.

Transitions:
- PH_ADDR_PEND goes to PH_ADDR_DONE on a strobe.
- PH_ADDR_DONE goes to PH_WR_FIRST when the write mode starts.
- PH_WR_FIRST goes to PH_WR_NEXT on its strobe.
- Entering the write mode from any other phase lands in PH_WR_NEXT.
- Every other mode change goes to that mode's phase.
- Standby forces PH_IDLE.

Top module: `rxg_exec_ram`

Mode codes on `mode_i`:

| Code | Mode |
|---|---|
| 0 | idle |
| 1 | load the data pointer |
| 2 | load the fetch pointer |
| 3 | write |
| 4 | data read |
| 5 | instruction fetch |
| 6, 7 | treated as idle |

## Requirements
- R1: After power-on reset, every RAM byte and both pointers are zero and the unlock register holds 0x00, so a fetch returns 0xFF.
- R2: A strobe in mode 1 loads the data pointer from the bus, and a strobe in mode 2 loads the fetch pointer from the bus.
- R3: Each strobe in mode 3 stores the bus byte at the data pointer, unless the pointer equals the unlock address, and then advances the data pointer by one, wrapping at the top.
- R4: In mode 4 the device drives the RAM byte at the data pointer onto the bus, and each strobe advances the pointer. The device drives the bus only in modes 4 and 5.
- R5: The first strobe of a write phase entered directly from a load phase that loaded the unlock address writes the unlock register. 0xAA opens fetches and any other byte, including 0xAB and 0x55, closes them.
- R6: A data read at the unlock address returns 0xFF and never the register contents. A store there leaves no RAM byte changed.
- R7: In mode 5, while open, the device drives the RAM byte at the fetch pointer. While closed it drives 0xFF. Every fetch strobe advances the fetch pointer in both cases, and fetches never change RAM.
- R8: A write strobe at the unlock address that is not the first strobe of a directly armed write phase changes neither the register nor RAM. This covers a later strobe in a stream and a write phase entered after an idle cycle.
- R9: While standby is high, the unlock register is cleared to 0x00, all strobes are ignored, and the device does not drive the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low power-on reset |
| standby_i | input | 1 | Standby request, clears the unlock register |
| mode_i | input | 3 | Bus mode code |
| stb_i | input | 1 | Strobe; each high cycle is one bus action |
| bus_io | inout | DW | Bidirectional data and address bus |

## Verification
Two functions can meet on one strobe: a data-pointer advance and an unlock-register write. This happens when a write stream started elsewhere walks onto the unlock address. The same strobe could then update the register, fill RAM, or do neither. The bench provokes this by starting a store stream one byte below the unlock address. It then keeps fetching after the stream, so a stray register write would show up as a fetch turning to 0xFF. A reference model of the pointer, phase and register decides each cycle's expected bus byte.

// File: rtl/rxg_pkg.sv
package rxg_pkg;

    typedef enum logic [2:0] {
        M_IDLE  = 3'd0,
        M_LDAR  = 3'd1,
        M_LSPC  = 3'd2,
        M_WRITE = 3'd3,
        M_READ  = 3'd4,
        M_FETCH = 3'd5
    } bus_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR_PEND,
        PH_ADDR_DONE,
        PH_WR_FIRST,
        PH_WR_NEXT,
        PH_READ,
        PH_FETCH,
        PH_SPC
    } phase_e;

endpackage

// File: rtl/rxg_phase_fsm.sv
module rxg_phase_fsm
    import rxg_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       standby_i,
    input  logic [2:0] mode_i,
    input  logic       stb_i,
    output logic       ldar_stb_o,
    output logic       lspc_stb_o,
    output logic       wr_first_stb_o,
    output logic       wr_next_stb_o,
    output logic       rd_stb_o,
    output logic       fetch_stb_o,
    output logic       drive_rd_o,
    output logic       drive_fetch_o
);

    phase_e state_q, cur_ph, state_d;
    logic   stb_ok;

    assign stb_ok = stb_i & ~standby_i;

    // Phase in effect this cycle: previous phase plus the present mode.
    always_comb begin
        cur_ph = PH_IDLE;
        if (!standby_i) begin
            case (mode_i)
                M_LDAR:  cur_ph = (state_q == PH_ADDR_DONE) ? PH_ADDR_DONE : PH_ADDR_PEND;
                M_LSPC:  cur_ph = PH_SPC;
                M_WRITE: begin
                    unique case (state_q)
                        PH_ADDR_DONE, PH_WR_FIRST: cur_ph = PH_WR_FIRST;
                        default:                   cur_ph = PH_WR_NEXT;
                    endcase
                end
                M_READ:  cur_ph = PH_READ;
                M_FETCH: cur_ph = PH_FETCH;
                default: cur_ph = PH_IDLE;
            endcase
        end
    end

    always_comb begin
        state_d = cur_ph;
        if (stb_ok) begin
            unique case (cur_ph)
                PH_ADDR_PEND: state_d = PH_ADDR_DONE;
                PH_WR_FIRST:  state_d = PH_WR_NEXT;
                default:      state_d = cur_ph;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= PH_IDLE;
        else         state_q <= state_d;
    end

    // Output decode.
    always_comb begin
        ldar_stb_o     = 1'b0;
        lspc_stb_o     = 1'b0;
        wr_first_stb_o = 1'b0;
        wr_next_stb_o  = 1'b0;
        rd_stb_o       = 1'b0;
        fetch_stb_o    = 1'b0;
        drive_rd_o     = 1'b0;
        drive_fetch_o  = 1'b0;
        unique case (cur_ph)
            PH_ADDR_PEND, PH_ADDR_DONE: ldar_stb_o = stb_ok;
            PH_SPC:       lspc_stb_o     = stb_ok;
            PH_WR_FIRST:  wr_first_stb_o = stb_ok;
            PH_WR_NEXT:   wr_next_stb_o  = stb_ok;
            PH_READ: begin
                rd_stb_o   = stb_ok;
                drive_rd_o = 1'b1;
            end
            PH_FETCH: begin
                fetch_stb_o   = stb_ok;
                drive_fetch_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R8: an armed first write is consumed by its strobe
    p_first_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_first_stb_o |=> !wr_first_stb_o);

    // R9: no strobe acts while in standby
    p_standby_mute_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        standby_i |-> !(ldar_stb_o || lspc_stb_o || wr_first_stb_o || wr_next_stb_o
                        || rd_stb_o || fetch_stb_o));

endmodule

// File: rtl/rxg_ptr.sv
module rxg_ptr #(
    parameter int unsigned AW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic          inc_i,
    input  logic [AW-1:0] din_i,
    output logic [AW-1:0] q_o
);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q_o <= '0;
        else if (load_i) q_o <= din_i;
        else if (inc_i)  q_o <= q_o + 1'b1;
    end

    // R3: every step advances the pointer by exactly one, with wrap
    p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && !load_i) |=> (q_o == AW'($past(q_o) + 1'b1)));

endmodule

// File: rtl/rxg_exec_gate.sv
module rxg_exec_gate #(
    parameter int unsigned     DW     = 8,
    parameter logic [DW-1:0]   UNLOCK = 8'hAA
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          standby_i,
    input  logic          wr_i,
    input  logic [DW-1:0] din_i,
    output logic          open_o
);

    logic [DW-1:0] gate_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        gate_q <= '0;
        else if (standby_i) gate_q <= '0;
        else if (wr_i)      gate_q <= din_i;
    end

    assign open_o = (gate_q == UNLOCK);

    // R9: standby wipes the register
    p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        standby_i |=> (gate_q == '0));

    // R8: without an armed write the register holds its value
    p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_i && !standby_i) |=> $stable(gate_q));

endmodule

// File: rtl/rxg_store.sv
module rxg_store #(
    parameter int unsigned    AW     = 8,
    parameter int unsigned    DW     = 8,
    parameter logic [AW-1:0]  HOLE   = '1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_d_i,
    input  logic [AW-1:0] raddr_f_i,
    output logic [DW-1:0] rdata_d_o,
    output logic [DW-1:0] rdata_f_o
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic          we_ok;

    // The unlock address is a hole: no RAM byte sits behind it.
    assign we_ok = we_i && (waddr_i != HOLE);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_ok) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_d_o = mem_q[raddr_d_i];
    assign rdata_f_o = mem_q[raddr_f_i];

    // R6: the hole byte never changes
    p_hole_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (mem_q[HOLE] == '0));

endmodule

// File: rtl/rxg_exec_ram.sv
module rxg_exec_ram
    import rxg_pkg::*;
#(
    parameter int unsigned   AW       = 8,
    parameter int unsigned   DW       = 8,
    parameter int unsigned   EER_ADDR = 255,
    parameter logic [DW-1:0] UNLOCK   = 8'hAA
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          standby_i,
    input  logic [2:0]    mode_i,
    input  logic          stb_i,
    inout  wire  [DW-1:0] bus_io
);

    localparam logic [AW-1:0] GATE_A = AW'(EER_ADDR);
    localparam logic [DW-1:0] FILL   = '1;

    logic          ldar_stb, lspc_stb, wr_first_stb, wr_next_stb, rd_stb, fetch_stb;
    logic          drive_rd, drive_fetch, drive;
    logic [AW-1:0] dar_q, spc_q, fetch_addr;
    logic [DW-1:0] rdata_d, rdata_f, dout;
    logic          gate_hit, fetch_open;

    rxg_phase_fsm u_fsm (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .standby_i      (standby_i),
        .mode_i         (mode_i),
        .stb_i          (stb_i),
        .ldar_stb_o     (ldar_stb),
        .lspc_stb_o     (lspc_stb),
        .wr_first_stb_o (wr_first_stb),
        .wr_next_stb_o  (wr_next_stb),
        .rd_stb_o       (rd_stb),
        .fetch_stb_o    (fetch_stb),
        .drive_rd_o     (drive_rd),
        .drive_fetch_o  (drive_fetch)
    );

    rxg_ptr #(.AW(AW)) u_dar (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (ldar_stb),
        .inc_i  (wr_first_stb | wr_next_stb | rd_stb),
        .din_i  (bus_io[AW-1:0]),
        .q_o    (dar_q)
    );

    rxg_ptr #(.AW(AW)) u_spc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (lspc_stb),
        .inc_i  (fetch_stb),
        .din_i  (bus_io[AW-1:0]),
        .q_o    (spc_q)
    );

    assign gate_hit = (dar_q == GATE_A);

    rxg_exec_gate #(.DW(DW), .UNLOCK(UNLOCK)) u_gate (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .standby_i (standby_i),
        .wr_i      (wr_first_stb & gate_hit),
        .din_i     (bus_io),
        .open_o    (fetch_open)
    );

    // The fetch pointer reaches the array only while the gate is open.
    assign fetch_addr = fetch_open ? spc_q : '0;

    rxg_store #(.AW(AW), .DW(DW), .HOLE(GATE_A)) u_mem (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (wr_first_stb | wr_next_stb),
        .waddr_i   (dar_q),
        .wdata_i   (bus_io),
        .raddr_d_i (dar_q),
        .raddr_f_i (fetch_addr),
        .rdata_d_o (rdata_d),
        .rdata_f_o (rdata_f)
    );

    always_comb begin
        if (drive_fetch)   dout = fetch_open ? rdata_f : FILL;
        else if (gate_hit) dout = FILL;
        else               dout = rdata_d;
    end

    assign drive  = drive_rd | drive_fetch;
    assign bus_io = drive ? dout : 'z;

    // R7: a closed gate yields the fill byte on fetch
    p_locked_fill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drive_fetch && !fetch_open) |-> (dout == FILL));

    // R6: the unlock register is never visible to a data read
    p_hidden_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drive_rd && gate_hit) |-> (dout == FILL));

    // R4: drive only in read or fetch modes
    p_drive_modes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drive |-> (mode_i == M_READ || mode_i == M_FETCH));

    // R9: silent bus during standby
    p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        standby_i |-> !drive);

endmodule

// File: tb/sim_rxg_exec_ram.sv
module sim_rxg_exec_ram;

    localparam int GATE = 255;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 1'b0;
    logic [2:0] mode = 3'd0;
    logic       stb = 1'b0;
    logic       tb_oe = 1'b0;
    logic [7:0] tb_val = 8'h00;
    wire  [7:0] bus;

    assign bus = tb_oe ? tb_val : 8'bz;

    always #2 clk = ~clk;

    rxg_exec_ram u0 (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .standby_i (standby),
        .mode_i    (mode),
        .stb_i     (stb),
        .bus_io    (bus)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Behavioural reference model
    byte unsigned m_mem [256];
    int           m_dar, m_spc;
    byte unsigned m_gate;
    int           m_prev;
    bit           m_loaded, m_first;

    task automatic model_reset();
        for (int i = 0; i < 256; i++) m_mem[i] = 0;
        m_dar = 0; m_spc = 0; m_gate = 0;
        m_prev = 0; m_loaded = 0; m_first = 0;
    endtask

    task automatic model_step(int m, bit s, byte unsigned v, bit sb);
        if (sb) begin
            m_gate = 0; m_loaded = 0; m_first = 0; m_prev = 0;
            return;
        end
        case (m)
            1: begin
                if (m_prev != 1) m_loaded = 0;
                m_first = 0;
                if (s) begin m_dar = v; m_loaded = 1; end
            end
            2: begin
                m_loaded = 0; m_first = 0;
                if (s) m_spc = v;
            end
            3: begin
                if (m_prev == 1)      m_first = m_loaded;
                else if (m_prev != 3) m_first = 0;
                m_loaded = 0;
                if (s) begin
                    if (m_first && m_dar == GATE) m_gate = v;
                    else if (m_dar != GATE)       m_mem[m_dar] = v;
                    m_dar = (m_dar + 1) % 256;
                    m_first = 0;
                end
            end
            4: begin
                m_loaded = 0; m_first = 0;
                if (s) m_dar = (m_dar + 1) % 256;
            end
            5: begin
                m_loaded = 0; m_first = 0;
                if (s) m_spc = (m_spc + 1) % 256;
            end
            default: begin m_loaded = 0; m_first = 0; end
        endcase
        m_prev = (m >= 1 && m <= 5) ? m : 0;
    endtask

    // One bus cycle: drive, compare the bus against the model, advance.
    task automatic cyc(int m, bit s, byte unsigned v, string tag, bit sb = 1'b0);
        byte unsigned exp_v;
        mode    = 3'(m);
        stb     = s;
        standby = sb;
        tb_oe   = (m >= 1 && m <= 3);
        tb_val  = v;
        #1;
        if (!sb && (m == 4 || m == 5)) begin
            if (m == 4) exp_v = (m_dar == GATE) ? 8'hFF : m_mem[m_dar];
            else        exp_v = (m_gate == 8'hAA) ? m_mem[m_spc] : 8'hFF;
            checks++;
            if (bus !== exp_v) begin
                errors++;
                $display("FAIL %s: bus got %02h expected %02h", tag, bus, exp_v);
            end
        end
        model_step(m, s, v, sb);
        @(negedge clk);
    endtask

    task automatic do_reset();
        mode = 3'd0; stb = 1'b0; standby = 1'b0; tb_oe = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic unlock(byte unsigned v, string tag);
        cyc(1, 1, 8'(GATE), tag);
        cyc(3, 1, v, tag);
        cyc(0, 0, 0, tag);
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        do_reset();

        // R1: reset state, fetch closed, RAM zero
        cyc(5, 0, 0, "R1");
        cyc(1, 1, 8'h40, "R1");
        cyc(4, 0, 0, "R1");

        // R2, R3: load pointer, store a stream
        cyc(1, 1, 8'h10, "R2");
        cyc(3, 1, 8'h11, "R3");
        cyc(3, 0, 8'h00, "R3");
        cyc(3, 1, 8'h22, "R3");
        cyc(3, 1, 8'h33, "R3");
        // R4: read back with post-increment
        cyc(1, 1, 8'h10, "R2");
        cyc(4, 1, 0, "R4");
        cyc(4, 1, 0, "R4");
        cyc(4, 0, 0, "R4");
        cyc(4, 1, 0, "R4");

        // R7: closed fetches give 0xFF but still step the fetch pointer
        cyc(2, 1, 8'h10, "R2");
        cyc(5, 1, 0, "R7");
        cyc(5, 1, 0, "R7");

        // R5: unlock, then fetch resumes at 0x12
        unlock(8'hAA, "R5");
        cyc(5, 1, 0, "R7");
        cyc(2, 1, 8'h10, "R2");
        cyc(5, 1, 0, "R7");
        cyc(5, 1, 0, "R7");

        // R6: data read at the unlock address is hidden
        cyc(1, 1, 8'(GATE), "R6");
        cyc(4, 0, 0, "R6");

        // R8: stream crossing the unlock address; second strobe lands on it
        cyc(1, 1, 8'hFE, "R8");
        cyc(3, 1, 8'h5E, "R8");
        cyc(3, 1, 8'h00, "R8");
        cyc(3, 1, 8'h77, "R8");
        cyc(2, 1, 8'hFE, "R8");
        cyc(5, 1, 0, "R8");
        cyc(5, 1, 0, "R6");
        cyc(5, 1, 0, "R8");

        // R8: write phase not directly after the load phase
        cyc(1, 1, 8'(GATE), "R8");
        cyc(0, 0, 0, "R8");
        cyc(3, 1, 8'h00, "R8");
        // R8: load mode entered but no strobe before the write
        cyc(1, 1, 8'(GATE), "R8");
        cyc(4, 0, 0, "R8");
        cyc(1, 0, 8'h00, "R8");
        cyc(3, 1, 8'h00, "R8");
        cyc(2, 1, 8'h10, "R8");
        cyc(5, 0, 0, "R8");

        // R5: relock with 0x55, near miss 0xAB, reopen
        unlock(8'h55, "R5");
        cyc(5, 0, 0, "R5");
        unlock(8'hAA, "R5");
        cyc(5, 0, 0, "R5");
        unlock(8'hAB, "R5");
        cyc(5, 0, 0, "R5");
        unlock(8'hAA, "R5");
        cyc(5, 0, 0, "R5");

        // R9: standby clears the gate and ignores strobes
        cyc(1, 1, 8'h11, "R9");
        cyc(3, 1, 8'hC3, "R9", 1'b1);
        cyc(5, 1, 0, "R9", 1'b1);
        cyc(0, 0, 0, "R9");
        cyc(5, 0, 0, "R9");
        cyc(1, 1, 8'h11, "R9");
        cyc(4, 0, 0, "R9");
        // the armed write cannot straddle standby
        cyc(1, 1, 8'(GATE), "R9");
        cyc(3, 0, 8'hAA, "R9", 1'b1);
        cyc(3, 1, 8'hAA, "R9");
        cyc(5, 0, 0, "R9");

        // R1: reset in mid run clears everything
        unlock(8'hAA, "R1");
        do_reset();
        cyc(5, 0, 0, "R1");
        cyc(1, 1, 8'h10, "R1");
        cyc(4, 0, 0, "R1");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule